// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

This block writes the stack frame for an interrupt or trap gate in a protected-mode processor model. A start strobe carries the already resolved gate facts: the gate size (16 or 32 bit), whether a new stack is used, whether the interrupted code ran in virtual-8086 mode, the stack base, starting pointer and stack-size mask, and the values to save. These values are the old data segment selectors, the old stack selector and pointer, the flags, the code selector, the return pointer and an optional error code.

The block issues one memory write request at a time with a valid/ready handshake. Before each write it lowers the stack pointer by the item size, and only the masked pointer bits change. When the last write is accepted it pulses done. On a new stack it also gives the new stack selector with its requested privilege bits replaced by the target privilege. After a virtual-8086 entry it signals that the four data segment selectors and their flags must be nulled. An entry from virtual-8086 mode that stays on the same stack does not write anything. It raises a general protection fault instead.

Top module: `irq_frame_pusher`

## Requirements
- R1: A start with `vm86_i`=1 and `new_stack_i`=0 makes no write and never raises `busy_o`. It pulses `fault_o` for one cycle, in the cycle after the start edge, with `fault_code_o` = `gate_sel_i` with bits [1:0] cleared.
- R2: The GS, FS, DS and ES selectors are written, in that order, only when both `new_stack_i` and `vm86_i` are 1. They are written before any other item.
- R3: On a new stack the old stack selector is written and then the old stack pointer. These two come after any selectors from R2 and before the flags.
- R4: Every frame then writes the flags, the old code selector and the return pointer, in that order. The error code follows last when `has_err_i`=1.
- R5: A 32-bit gate (`gate32_i`=1) writes every item with `wr_wide_o`=1 and full 32-bit data. A 16-bit gate writes with `wr_wide_o`=0 and data bits [31:16] at zero, with only bits [15:0] of the item.
- R6: Each write first lowers the pointer by 4 (wide) or 2 (narrow), touching only the bits set in `stk_mask_i`. The write address is `stk_base_i` + (pointer & mask). `sp_o` holds the final pointer, with the unmasked bits unchanged.
- R7: `seg_clear_o` pulses together with `done_o` exactly when the frame used a new stack from virtual-8086 mode.
- R8: `ss_load_o` pulses with `done_o` on a new-stack frame. At that time `ss_sel_o` = {`new_ss_sel_i`[15:2], `target_dpl_i`}.
- R9: `busy_o` is high from the cycle after the start edge until the last write is accepted. `done_o` is high for exactly the one cycle after that acceptance. While `wr_ready_i` is low, a pending request keeps its address and data.
- R10: A start strobe while `busy_o` is high is ignored. It adds no write and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a frame |
| gate32_i | input | 1 | 1: 32-bit gate, 0: 16-bit gate |
| new_stack_i | input | 1 | Entry switches to a new stack |
| vm86_i | input | 1 | Interrupted code was in virtual-8086 mode |
| has_err_i | input | 1 | Push an error code |
| target_dpl_i | input | 2 | Privilege level of the target code |
| gate_sel_i | input | 16 | Gate selector, used for the fault code |
| new_ss_sel_i | input | 16 | Stack selector to load on a new stack |
| stk_base_i | input | 32 | Base of the stack written to |
| stk_ptr_i | input | 32 | Starting stack pointer |
| stk_mask_i | input | 32 | Stack-size mask |
| old_gs_i | input | 16 | Old GS selector |
| old_fs_i | input | 16 | Old FS selector |
| old_ds_i | input | 16 | Old DS selector |
| old_es_i | input | 16 | Old ES selector |
| old_ss_i | input | 16 | Old stack selector |
| old_sp_i | input | 32 | Old stack pointer |
| flags_i | input | 32 | Flags to save |
| cs_sel_i | input | 16 | Old code selector |
| ret_ptr_i | input | 32 | Return instruction pointer |
| err_code_i | input | 32 | Error code |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_valid_o | output | 1 | Write request pending |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_wide_o | output | 1 | 1: 4-byte write, 0: 2-byte write |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame finished (one cycle) |
| sp_o | output | 32 | Stack pointer after the pushes |
| ss_load_o | output | 1 | Load new stack selector (with done) |
| ss_sel_o | output | 16 | New stack selector value |
| seg_clear_o | output | 1 | Null ES/DS/FS/GS and their flags |
| fault_o | output | 1 | General protection fault pulse |
| fault_code_o | output | 16 | Fault error code |

## Verification
The bench checks the item order and count of the push sequence, since that depends on both the new-stack and virtual-8086 flags. A design that pushed the selectors on a same-stack entry, or without the virtual-8086 flag, would produce extra writes that the scoreboard rejects. A pointer that starts at 2 under a 16-bit mask must wrap inside the mask and keep the upper bits; a design that ran the full-width subtraction would write outside the segment and report the wrong final pointer. The bench also stalls `wr_ready_i` at random and sends a second start while a frame runs. A design that lost a stalled item, or restarted its sequence on the second start, would break the order or the count. The faulting entry and the one-cycle timing of done are checked against the cycle of the last accepted write.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
  localparam int SEL_W   = 16;
  localparam int WORD_W  = 32;
  localparam int N_ITEMS = 10;
  localparam int IDX_W   = $clog2(N_ITEMS);

  // Enum order is push order
  typedef enum logic [IDX_W-1:0] {
    IT_GS, IT_FS, IT_DS, IT_ES, IT_SS, IT_SP, IT_FLAGS, IT_CS, IT_RET, IT_ERR
  } item_e;

  typedef struct packed {
    logic [SEL_W-1:0]  gs;
    logic [SEL_W-1:0]  fs;
    logic [SEL_W-1:0]  ds;
    logic [SEL_W-1:0]  es;
    logic [SEL_W-1:0]  ss;
    logic [WORD_W-1:0] sp;
    logic [WORD_W-1:0] flags;
    logic [SEL_W-1:0]  cs;
    logic [WORD_W-1:0] ret;
    logic [WORD_W-1:0] err;
  } frame_ops_t;

  typedef struct packed {
    logic wide;
    logic vm86;
    logic new_stack;
  } frame_cfg_t;
endpackage

// File: rtl/irq_item_pick.sv
module irq_item_pick
  import irq_frame_pkg::*;
#(
  parameter int N = N_ITEMS
) (
  input  logic [N-1:0] pend_i,
  output item_e        item_o,
  output logic [N-1:0] item_oh_o
);
  always_comb begin
    item_o    = IT_GS;
    item_oh_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        item_o    = item_e'(i);
        item_oh_o = '0;
        item_oh_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_item_data.sv
module irq_item_data
  import irq_frame_pkg::*;
(
  input  item_e             item_i,
  input  frame_ops_t        ops_i,
  input  logic              wide_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int HALF_W = WORD_W / 2;
  logic [WORD_W-1:0] raw;

  always_comb begin
    unique case (item_i)
      IT_GS:    raw = WORD_W'(ops_i.gs);
      IT_FS:    raw = WORD_W'(ops_i.fs);
      IT_DS:    raw = WORD_W'(ops_i.ds);
      IT_ES:    raw = WORD_W'(ops_i.es);
      IT_SS:    raw = WORD_W'(ops_i.ss);
      IT_SP:    raw = ops_i.sp;
      IT_FLAGS: raw = ops_i.flags;
      IT_CS:    raw = WORD_W'(ops_i.cs);
      IT_RET:   raw = ops_i.ret;
      IT_ERR:   raw = ops_i.err;
      default:  raw = '0;
    endcase
  end

  assign data_o = wide_i ? raw : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
endmodule

// File: rtl/irq_sp_step.sv
module irq_sp_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] base_i,
  input  logic          wide_i,
  output logic [AW-1:0] sp_next_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] step, dec;

  assign step      = wide_i ? AW'(4) : AW'(2);
  assign dec       = sp_i - step;
  assign sp_next_o = (sp_i & ~mask_i) | (dec & mask_i);
  assign addr_o    = base_i + (sp_next_o & mask_i);
endmodule

// File: rtl/irq_frame_ctrl.sv
module irq_frame_ctrl
  import irq_frame_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  frame_cfg_t        cfg_i,
  input  logic              has_err_i,
  input  logic [1:0]        dpl_i,
  input  logic [SEL_W-1:0]  gate_sel_i,
  input  logic [SEL_W-1:0]  new_ss_sel_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic [AW-1:0]     mask_i,
  input  frame_ops_t        ops_i,
  input  logic [N_ITEMS-1:0] item_oh_i,
  input  logic [AW-1:0]     sp_next_i,
  input  logic              wr_ready_i,
  output logic [N_ITEMS-1:0] pend_o,
  output frame_cfg_t        cfg_o,
  output frame_ops_t        ops_o,
  output logic [AW-1:0]     sp_o,
  output logic [AW-1:0]     base_o,
  output logic [AW-1:0]     mask_o,
  output logic              push_o,
  output logic              done_o,
  output logic              ss_load_o,
  output logic [SEL_W-1:0]  ss_sel_o,
  output logic              seg_clear_o,
  output logic              fault_o,
  output logic [SEL_W-1:0]  fault_code_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_DONE} state_e;

  state_e             state_q;
  logic [N_ITEMS-1:0] pend_q, en_mask, pend_left;
  frame_cfg_t         cfg_q;
  frame_ops_t         ops_q;
  logic [AW-1:0]      sp_q, base_q, mask_q;
  logic [SEL_W-1:0]   ss_sel_q, fault_code_q;
  logic               fault_q, go, bad, accept;

  assign go        = start_i && (state_q != ST_PUSH);
  assign bad       = cfg_i.vm86 && !cfg_i.new_stack;
  assign accept    = (state_q == ST_PUSH) && wr_ready_i;
  assign pend_left = pend_q & ~item_oh_i;

  always_comb begin
    en_mask           = '0;
    en_mask[IT_GS]    = cfg_i.new_stack && cfg_i.vm86;
    en_mask[IT_FS]    = cfg_i.new_stack && cfg_i.vm86;
    en_mask[IT_DS]    = cfg_i.new_stack && cfg_i.vm86;
    en_mask[IT_ES]    = cfg_i.new_stack && cfg_i.vm86;
    en_mask[IT_SS]    = cfg_i.new_stack;
    en_mask[IT_SP]    = cfg_i.new_stack;
    en_mask[IT_FLAGS] = 1'b1;
    en_mask[IT_CS]    = 1'b1;
    en_mask[IT_RET]   = 1'b1;
    en_mask[IT_ERR]   = has_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pend_q       <= '0;
      cfg_q        <= '0;
      ops_q        <= '0;
      sp_q         <= '0;
      base_q       <= '0;
      mask_q       <= '0;
      ss_sel_q     <= '0;
      fault_q      <= 1'b0;
      fault_code_q <= '0;
    end else begin
      fault_q <= 1'b0;
      unique case (state_q)
        ST_PUSH: begin
          if (accept) begin
            sp_q   <= sp_next_i;
            pend_q <= pend_left;
            if (pend_left == '0) state_q <= ST_DONE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          if (go && bad) begin
            fault_q      <= 1'b1;
            fault_code_q <= {gate_sel_i[SEL_W-1:2], 2'b00};
          end else if (go) begin
            state_q  <= ST_PUSH;
            pend_q   <= en_mask;
            cfg_q    <= cfg_i;
            ops_q    <= ops_i;
            sp_q     <= ptr_i;
            base_q   <= base_i;
            mask_q   <= mask_i;
            ss_sel_q <= {new_ss_sel_i[SEL_W-1:2], dpl_i};
          end
        end
      endcase
    end
  end

  assign pend_o       = pend_q;
  assign cfg_o        = cfg_q;
  assign ops_o        = ops_q;
  assign sp_o         = sp_q;
  assign base_o       = base_q;
  assign mask_o       = mask_q;
  assign push_o       = (state_q == ST_PUSH);
  assign done_o       = (state_q == ST_DONE);
  assign ss_load_o    = done_o && cfg_q.new_stack;
  assign ss_sel_o     = ss_sel_q;
  assign seg_clear_o  = done_o && cfg_q.new_stack && cfg_q.vm86;
  assign fault_o      = fault_q;
  assign fault_code_o = fault_code_q;
endmodule

// File: rtl/irq_frame_pusher.sv
module irq_frame_pusher
  import irq_frame_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        gate32_i,
  input  logic        new_stack_i,
  input  logic        vm86_i,
  input  logic        has_err_i,
  input  logic [1:0]  target_dpl_i,
  input  logic [15:0] gate_sel_i,
  input  logic [15:0] new_ss_sel_i,
  input  logic [AW-1:0] stk_base_i,
  input  logic [AW-1:0] stk_ptr_i,
  input  logic [AW-1:0] stk_mask_i,
  input  logic [15:0] old_gs_i,
  input  logic [15:0] old_fs_i,
  input  logic [15:0] old_ds_i,
  input  logic [15:0] old_es_i,
  input  logic [15:0] old_ss_i,
  input  logic [31:0] old_sp_i,
  input  logic [31:0] flags_i,
  input  logic [15:0] cs_sel_i,
  input  logic [31:0] ret_ptr_i,
  input  logic [31:0] err_code_i,
  input  logic        wr_ready_i,
  output logic        wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0] wr_data_o,
  output logic        wr_wide_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [AW-1:0] sp_o,
  output logic        ss_load_o,
  output logic [15:0] ss_sel_o,
  output logic        seg_clear_o,
  output logic        fault_o,
  output logic [15:0] fault_code_o
);
  frame_cfg_t         cfg_in, cfg_q;
  frame_ops_t         ops_in, ops_q;
  logic [N_ITEMS-1:0] pend, item_oh;
  item_e              item;
  logic [AW-1:0]      sp_q, base_q, mask_q, sp_next, addr;
  logic               push;

  assign cfg_in = '{wide: gate32_i, vm86: vm86_i, new_stack: new_stack_i};
  assign ops_in = '{gs: old_gs_i, fs: old_fs_i, ds: old_ds_i, es: old_es_i,
                    ss: old_ss_i, sp: old_sp_i, flags: flags_i, cs: cs_sel_i,
                    ret: ret_ptr_i, err: err_code_i};

  irq_frame_ctrl #(.AW(AW)) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .cfg_i(cfg_in), .has_err_i, .dpl_i(target_dpl_i),
    .gate_sel_i, .new_ss_sel_i,
    .base_i(stk_base_i), .ptr_i(stk_ptr_i), .mask_i(stk_mask_i),
    .ops_i(ops_in), .item_oh_i(item_oh), .sp_next_i(sp_next), .wr_ready_i,
    .pend_o(pend), .cfg_o(cfg_q), .ops_o(ops_q), .sp_o(sp_q),
    .base_o(base_q), .mask_o(mask_q), .push_o(push), .done_o,
    .ss_load_o, .ss_sel_o, .seg_clear_o, .fault_o, .fault_code_o
  );

  irq_item_pick #(.N(N_ITEMS)) i_pick (
    .pend_i(pend), .item_o(item), .item_oh_o(item_oh)
  );

  irq_item_data i_data (
    .item_i(item), .ops_i(ops_q), .wide_i(cfg_q.wide), .data_o(wr_data_o)
  );

  irq_sp_step #(.AW(AW)) i_sp (
    .sp_i(sp_q), .mask_i(mask_q), .base_i(base_q), .wide_i(cfg_q.wide),
    .sp_next_o(sp_next), .addr_o(addr)
  );

  assign wr_valid_o = push;
  assign wr_addr_o  = addr;
  assign wr_wide_o  = cfg_q.wide;
  assign busy_o     = push;
  assign sp_o       = sp_q;
endmodule

// File: rtl/irq_frame_pusher_chk.sv
module irq_frame_pusher_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [31:0]   wr_data_o,
  input logic          wr_wide_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          ss_load_o,
  input logic          seg_clear_o,
  input logic          fault_o
);
  // R9
  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o) && $past(wr_ready_i));
  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  a_r1_fault_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !wr_valid_o && !busy_o);
  // R7
  a_r7_clear_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_clear_o |-> done_o && ss_load_o);
  // R8
  a_r8_load_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_load_o |-> done_o);
  // R5
  a_r5_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_wide_o |-> wr_data_o[31:16] == 16'h0);
endmodule

bind irq_frame_pusher irq_frame_pusher_chk #(.AW(AW)) i_chk (
  .clk_i, .rst_ni, .wr_valid_o, .wr_ready_i, .wr_addr_o, .wr_data_o,
  .wr_wide_o, .busy_o, .done_o, .ss_load_o, .seg_clear_o, .fault_o
);

// File: tb/test_irq_frame_pusher.sv
`timescale 1ns/1ps
module test_irq_frame_pusher;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, gate32_i = 0, new_stack_i = 0, vm86_i = 0, has_err_i = 0;
  logic [1:0] target_dpl_i = 0;
  logic [15:0] gate_sel_i = 0, new_ss_sel_i = 0;
  logic [31:0] stk_base_i = 0, stk_ptr_i = 0, stk_mask_i = 0;
  logic [15:0] old_gs_i = 16'h0a1b, old_fs_i = 16'h0b2c, old_ds_i = 16'h0c3d,
               old_es_i = 16'h0d4e, old_ss_i = 16'h0e5f, cs_sel_i = 16'h1f60;
  logic [31:0] old_sp_i = 32'hcafe1234, flags_i = 32'h00020246,
               ret_ptr_i = 32'h8001_2345, err_code_i = 32'h0000_0abc;
  logic wr_ready_i = 1'b1;
  logic wr_valid_o, wr_wide_o, busy_o, done_o, ss_load_o, seg_clear_o, fault_o;
  logic [31:0] wr_addr_o, wr_data_o, sp_o;
  logic [15:0] ss_sel_o, fault_code_o;

  irq_frame_pusher i_irq_frame_pusher (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  int cyc = 0, last_pop = -10, fault_seen = 0, stall_mode = 0;
  logic [15:0] lfsr = 16'hace1;
  logic [64:0] exp_q[$];
  logic [31:0] m_sp, m_base, m_mask;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready_i = stall_mode ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare each accepted write with the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && fault_o) fault_seen++;
    if (rst_ni && wr_valid_o && wr_ready_i) begin
      if (exp_q.size() == 0) chk(0, "R2/R4/R10 extra write", {wr_addr_o, wr_data_o}, 0);
      else begin
        logic [64:0] e;
        e = exp_q.pop_front();
        chk({wr_addr_o, wr_data_o, wr_wide_o} == e, "R2-R6 push item",
            {wr_addr_o, wr_data_o}, e[64:1]);
        last_pop = cyc;
      end
    end
  end

  function automatic void exp_push(input logic [31:0] v, input bit wide);
    logic [31:0] a, d;
    m_sp = (m_sp & ~m_mask) | ((m_sp - (wide ? 32'd4 : 32'd2)) & m_mask);
    a = m_base + (m_sp & m_mask);
    d = wide ? v : {16'h0, v[15:0]};
    exp_q.push_back({a, d, wide});
  endfunction

  task automatic run_frame(input bit w, input bit ns, input bit vm, input bit he,
                           input logic [31:0] base, input logic [31:0] ptr,
                           input logic [31:0] mask, input bit restart);
    int wd = 0;
    @(negedge clk_i);
    gate32_i = w; new_stack_i = ns; vm86_i = vm; has_err_i = he;
    stk_base_i = base; stk_ptr_i = ptr; stk_mask_i = mask;
    target_dpl_i = 2'd3; new_ss_sel_i = 16'h0028;
    m_sp = ptr; m_base = base; m_mask = mask;
    // R2 selectors, R3 stack, R4 tail
    if (ns && vm) begin
      exp_push(32'(old_gs_i), w); exp_push(32'(old_fs_i), w);
      exp_push(32'(old_ds_i), w); exp_push(32'(old_es_i), w);
    end
    if (ns) begin exp_push(32'(old_ss_i), w); exp_push(old_sp_i, w); end
    exp_push(flags_i, w); exp_push(32'(cs_sel_i), w); exp_push(ret_ptr_i, w);
    if (he) exp_push(err_code_i, w);
    fault_seen = 0;
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    if (restart) begin
      // R10: faulting config strobed mid-frame must be ignored
      @(negedge clk_i);
      vm86_i = 1; new_stack_i = 0; start_i = 1;
      @(negedge clk_i);
      start_i = 0;
    end
    while (!done_o && wd < 500) begin @(negedge clk_i); wd++; end
    chk(wd < 500, "R9 done seen", wd, 0);
    chk(exp_q.size() == 0, "R2/R4 item count", exp_q.size(), 0);
    chk(last_pop == cyc - 1, "R9 done one cycle after last accept", last_pop, cyc - 1);
    chk(busy_o == 1'b0, "R9 busy low at done", busy_o, 0);
    chk(sp_o == m_sp, "R6 final pointer", sp_o, m_sp);
    chk(seg_clear_o == (ns && vm), "R7 segment clear", seg_clear_o, ns && vm);
    chk(ss_load_o == ns, "R8 stack load", ss_load_o, ns);
    if (ns) chk(ss_sel_o == 16'h002b, "R8 stack selector", ss_sel_o, 16'h002b);
    if (restart) chk(fault_seen == 0, "R10 no fault from ignored start", fault_seen, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 done single pulse", done_o, 0);
    exp_q.delete();
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        #20 rst_ni = 1;
        @(negedge clk_i);
        chk(!busy_o && !wr_valid_o && !done_o && !fault_o, "R9 reset state",
            {busy_o, wr_valid_o, done_o, fault_o}, 0);
        run_frame(1, 0, 0, 0, 32'h0010_0000, 32'h0000_1000, 32'hffff_ffff, 0); // R4, R5
        stall_mode = 1;
        run_frame(1, 1, 1, 1, 32'h0020_0000, 32'h0000_8000, 32'hffff_ffff, 0); // R2, R3, R7
        run_frame(0, 1, 0, 1, 32'h0003_0000, 32'h0000_0400, 32'h0000_ffff, 0); // R5 narrow
        run_frame(1, 0, 0, 1, 32'h0040_0000, 32'h1234_0002, 32'h0000_ffff, 0); // R6 wrap
        run_frame(0, 1, 1, 0, 32'h0005_0000, 32'hab00_0001, 32'h0000_ffff, 1); // R10
        // R1: same-stack entry from virtual-8086 mode faults
        stall_mode = 0;
        @(negedge clk_i);
        vm86_i = 1; new_stack_i = 0; gate_sel_i = 16'h1237; start_i = 1;
        @(negedge clk_i);
        start_i = 0;
        chk(fault_o == 1'b1, "R1 fault pulse", fault_o, 1);
        chk(fault_code_o == 16'h1234, "R1 fault code", fault_code_o, 16'h1234);
        chk(!busy_o && !wr_valid_o, "R1 no write", {busy_o, wr_valid_o}, 0);
        @(negedge clk_i);
        chk(fault_o == 1'b0 && !wr_valid_o, "R1 fault one cycle", fault_o, 0);
      end
      begin
        while (wd < 20000) begin @(posedge clk_i); wd++; end
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule